// File: doc/BRIEF.md
# Run-Time Configurable Digit-Serial Galois Field Multiplier

This block multiplies two elements of GF(2^m) for any field degree m from 2 to 8. Both m and the field polynomial come in with each operation, so one instance serves several codes without rebuilding. The polynomial input carries the coefficients of x^0 up to x^(m-1). The x^m term is implied.

The multiplication runs in two separate stages. The first is a full-width carry-less multiply-accumulate stage. It forms the unreduced product of up to 2m-1 coefficients in a single cycle. The second is a degree-reduction stage. It folds the coefficients above degree m-1 back into the field, a few at a time, with a digit of 2 or 4 coefficients per cycle chosen for each operation. A small step controller sequences the two stages. A single-cycle start pulse begins an operation, and a single-cycle done pulse marks the result.

Top module: `gf_digit_mul`

## Requirements
- R1: While rst_ni is low, and until the first operation completes, busy_o, done_o and result_o are all 0.
- R2: result_o equals a times b modulo the field polynomial x^m + poly_i, taken over GF(2). This holds for every m from 2 to 8, for any polynomial, and for both reduction digit sizes.
- R3: Bits of poly_i at position m and above do not affect the result.
- R4: Bits of a_i and b_i at position m and above do not affect the result.
- R5: When done_o is high, every bit of result_o at position m and above is 0.
- R6: red_wide_i = 0 selects a digit of 2 coefficients per reduction cycle, and red_wide_i = 1 selects 4. Let E be the rising edge that samples start. done_o rises at the rising edge that comes 1 + ceil((m-1)/d) edges after E.
- R7: done_o is high for exactly one cycle. result_o holds its value until the next done_o.
- R8: While busy_o is high, start_i is ignored. The operation in flight finishes with its own result, and no extra done_o follows.
- R9: busy_o is high from the edge after start is accepted until the done edge. It is low in the cycle where done_o is high, and a new start is accepted in that cycle.
- R10: An m_i value below 2 acts as m = 2, and a value above 8 acts as m = 8. This applies to both the result and the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| m_i | input | 4 | Field degree m |
| poly_i | input | 8 | Field polynomial coefficients x^0..x^(m-1) |
| red_wide_i | input | 1 | Reduction digit: 0 = 2 coefficients, 1 = 4 coefficients |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; result_o valid |
| result_o | output | 8 | Product in GF(2^m) |

## Verification
The bench covers every degree from m = 2 to m = 8 with both digit sizes, many random operands and random polynomials, and it compares each result against a bit-serial shift-and-add model. An error in the reduction step shows up two ways. If the cell folds the coefficients within one digit in the wrong order, some products carry a stray high bit back. If the cell stops one step early, the masked result is wrong even though the latency looks right. An off-by-one in the step count fails the per-operation latency check, which differs between the two digit sizes for most m. Further cases cover garbage bits above m in the polynomial and the operands, out-of-range m, and a start pulse sent mid-operation. A design that wrongly accepts that mid-operation start either corrupts the in-flight result or produces an unexpected done.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_RED} gf_state_e;

  function automatic logic [7:0] low_mask8(input logic [3:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i < int'(m));
    return r;
  endfunction
endpackage

// File: rtl/gf_mac_cell.sv
module gf_mac_cell #(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W - 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] prod_o
);
  logic [PW-1:0] row [W];

  for (genvar i = 0; i < W; i++) begin : g_row
    assign row[i] = b_i[i] ? (PW'(a_i) << i) : '0;
  end

  always_comb begin
    prod_o = '0;
    for (int i = 0; i < int'(W); i++) prod_o = prod_o ^ row[i];
  end
endmodule

// File: rtl/gf_red_cell.sv
module gf_red_cell #(
  parameter int unsigned W     = 8,
  parameter int unsigned DIGIT = 2,
  localparam int unsigned PW   = 2 * W - 1,
  localparam int unsigned DW   = $clog2(PW),
  localparam int unsigned MW   = $clog2(W + 1)
) (
  input  logic [PW-1:0] prod_i,
  input  logic [DW-1:0] deg_i,
  input  logic [MW-1:0] m_i,
  input  logic [W-1:0]  poly_i,
  output logic [PW-1:0] prod_o
);
  logic [PW-1:0] full;

  // full field polynomial with the implied x^m term
  assign full = PW'(poly_i) | (PW'(1) << m_i);

  // fold highest coefficient first: a lower fold may set bits inside the digit
  always_comb begin
    prod_o = prod_i;
    for (int k = 0; k < int'(DIGIT); k++) begin
      if (int'(deg_i) - k >= int'(m_i)) begin
        if (prod_o[DW'(int'(deg_i) - k)])
          prod_o = prod_o ^ (full << DW'(int'(deg_i) - k - int'(m_i)));
      end
    end
  end
endmodule

// File: rtl/gf_step_ctrl.sv
module gf_step_ctrl
  import gf_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned D_NARROW = 2,
  parameter int unsigned D_WIDE   = 4,
  localparam int unsigned PW      = 2 * W - 1,
  localparam int unsigned DW      = $clog2(PW),
  localparam int unsigned MW      = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] m_i,
  input  logic          wide_i,
  output logic          accept_o,
  output logic          mac_o,
  output logic          red_o,
  output logic          last_o,
  output logic          busy_o,
  output logic [DW-1:0] deg_o
);
  gf_state_e     state_q, state_d;
  logic [DW-1:0] deg_q, deg_d;
  int            dig;

  assign dig      = wide_i ? int'(D_WIDE) : int'(D_NARROW);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign mac_o    = (state_q == ST_MAC);
  assign red_o    = (state_q == ST_RED);
  assign last_o   = red_o && (int'(deg_q) < int'(m_i) + dig);
  assign busy_o   = (state_q != ST_IDLE);
  assign deg_o    = deg_q;

  always_comb begin
    state_d = state_q;
    deg_d   = deg_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_MAC;
      ST_MAC: begin
        state_d = ST_RED;
        deg_d   = DW'(2 * int'(m_i) - 2);
      end
      ST_RED: begin
        if (last_o) state_d = ST_IDLE;
        else        deg_d   = DW'(int'(deg_q) - dig);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      deg_q   <= '0;
    end else begin
      state_q <= state_d;
      deg_q   <= deg_d;
    end
  end

  assert_deg_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (red_o && !last_o) |=> (int'(deg_q) == int'($past(deg_q)) - dig));
  assert_mac_then_red_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_o |=> red_o);
  assert_idle_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
endmodule

// File: rtl/gf_digit_mul.sv
module gf_digit_mul
  import gf_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned M_MIN    = 2,
  parameter int unsigned D_NARROW = 2,
  parameter int unsigned D_WIDE   = 4,
  localparam int unsigned PW      = 2 * W - 1,
  localparam int unsigned DW      = $clog2(PW),
  localparam int unsigned MW      = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [3:0]   m_i,
  input  logic [W-1:0] poly_i,
  input  logic         red_wide_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic [MW-1:0] m_eff, m_q;
  logic [W-1:0]  mask_in, mask_q;
  logic [W-1:0]  a_q, b_q, poly_q;
  logic          wide_q;
  logic [PW-1:0] prod_q, mac_out, red_n_out, red_w_out, red_out;
  logic [W-1:0]  res_q;
  logic          done_q;
  logic          accept, mac_en, red_en, last;
  logic [DW-1:0] deg;

  always_comb begin
    if (int'(m_i) < int'(M_MIN)) m_eff = MW'(M_MIN);
    else if (int'(m_i) > int'(W)) m_eff = MW'(W);
    else m_eff = MW'(m_i);
  end

  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      mask_in[i] = (i < int'(m_eff));
      mask_q[i]  = (i < int'(m_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= MW'(M_MIN);
      a_q    <= '0;
      b_q    <= '0;
      poly_q <= '0;
      wide_q <= 1'b0;
    end else if (accept) begin
      m_q    <= m_eff;
      a_q    <= a_i & mask_in;
      b_q    <= b_i & mask_in;
      poly_q <= poly_i & mask_in;
      wide_q <= red_wide_i;
    end
  end

  gf_step_ctrl #(.W(W), .D_NARROW(D_NARROW), .D_WIDE(D_WIDE)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .m_i     (m_q),
    .wide_i  (wide_q),
    .accept_o(accept),
    .mac_o   (mac_en),
    .red_o   (red_en),
    .last_o  (last),
    .busy_o  (busy_o),
    .deg_o   (deg)
  );

  gf_mac_cell #(.W(W)) u_mac (
    .a_i   (a_q),
    .b_i   (b_q),
    .prod_o(mac_out)
  );

  gf_red_cell #(.W(W), .DIGIT(D_NARROW)) u_red_narrow (
    .prod_i(prod_q),
    .deg_i (deg),
    .m_i   (m_q),
    .poly_i(poly_q),
    .prod_o(red_n_out)
  );

  gf_red_cell #(.W(W), .DIGIT(D_WIDE)) u_red_wide (
    .prod_i(prod_q),
    .deg_i (deg),
    .m_i   (m_q),
    .poly_i(poly_q),
    .prod_o(red_w_out)
  );

  assign red_out = wide_q ? red_w_out : red_n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (mac_en) prod_q <= mac_out;
      else if (red_en) prod_q <= red_out;
      if (last) begin
        res_q  <= red_out[W-1:0] & mask_q;
        done_q <= 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(result_o)));
  assert_result_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((result_o & ~low_mask8(4'(m_q))) == '0));
  assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(poly_q)));
  assert_prod_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_en |-> ((prod_q >> (int'(deg) + 1)) == '0));
  assert_not_busy_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/gf_digit_mul_tb.sv
`timescale 1ns/1ps
module gf_digit_mul_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] m_in = 4'd8;
  logic [7:0] poly = 8'h1D;
  logic       wide = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       busy, done;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  gf_digit_mul u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .m_i(m_in), .poly_i(poly),
    .red_wide_i(wide), .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .result_o(result)
  );

  function automatic int clamp_m(input logic [3:0] m);
    if (m < 2) return 2;
    if (m > 8) return 8;
    return int'(m);
  endfunction

  // bit-serial shift-and-add model
  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y,
                                         input logic [7:0] p, input int m);
    logic [8:0] r = '0;
    logic [8:0] full;
    logic [7:0] msk = '0;
    for (int i = 0; i < m; i++) msk[i] = 1'b1;
    full = {1'b0, p & msk} | (9'd1 << m);
    x = x & msk;
    y = y & msk;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[m]) r = r ^ full;
      if (y[i]) r = r ^ {1'b0, x};
    end
    return r[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare on every done pulse (R2 R3 R4 R5 R8 R10)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected done", int'(result), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(result == e, "R2 product", int'(result), int'(e));
      end
    end
  end

  task automatic run_op(input logic [7:0] x, input logic [7:0] y, input logic [7:0] p,
                        input logic [3:0] m, input logic w, input bit poke);
    int mm, k, cnt;
    logic [7:0] held;
    mm = clamp_m(m);
    k  = (mm - 1 + (w ? 4 : 2) - 1) / (w ? 4 : 2);
    exp_q.push_back(ref_mul(x, y, p, mm));
    @(negedge clk);
    a = x; b = y; poly = p; m_in = m; wide = w; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    cnt = 1;
    if (poke) begin
      // R8: a start while busy with other operands must be ignored
      a = ~x; b = ~y; poly = ~p; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    while (!done && cnt < 40) begin
      @(posedge clk);
      @(negedge clk);
      if (!done) cnt++;
    end
    check(cnt == 1 + k, "R6 latency", cnt, 1 + k);
    check(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
    held = result;
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    check(result == held, "R7 result held", int'(result), int'(held));
  endtask

  initial begin
    logic [7:0] pl [9];
    pl[2] = 8'h03; pl[3] = 8'h03; pl[4] = 8'h03; pl[5] = 8'h05;
    pl[6] = 8'h03; pl[7] = 8'h03; pl[8] = 8'h1D;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && result == 0, "R1 reset state",
          {busy, done, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && result == 0, "R1 idle after reset",
          {busy, done, result}, 0);

    // R2 R6: all degrees, both digit sizes, primitive and random polynomials
    for (int m = 2; m <= 8; m++) begin
      for (int w = 0; w < 2; w++) begin
        run_op(8'hFF, 8'hFF, pl[m], 4'(m), w[0], 1'b0);
        run_op(8'h01, 8'h00, pl[m], 4'(m), w[0], 1'b0);
        for (int t = 0; t < 12; t++)
          run_op(8'($urandom), 8'($urandom), pl[m], 4'(m), w[0], 1'b0);
        for (int t = 0; t < 6; t++)
          run_op(8'($urandom), 8'($urandom), 8'($urandom), 4'(m), w[0], 1'b0);
      end
    end
    // R3 R4: garbage above m in polynomial and operands
    run_op(8'hF5, 8'hE3, 8'hF3, 4'd3, 1'b0, 1'b0);
    run_op(8'hA9, 8'h77, 8'hE5, 4'd5, 1'b1, 1'b0);
    run_op(8'hCD, 8'hBF, 8'hC3, 4'd6, 1'b0, 1'b0);
    // R10: out-of-range degrees
    run_op(8'h03, 8'h02, 8'h03, 4'd0, 1'b0, 1'b0);
    run_op(8'h01, 8'h03, 8'h01, 4'd1, 1'b1, 1'b0);
    run_op(8'hB7, 8'h5C, 8'h1D, 4'd15, 1'b0, 1'b0);
    run_op(8'h9A, 8'hC4, 8'h2B, 4'd9, 1'b1, 1'b0);
    // R8: start poked while busy
    run_op(8'h57, 8'h83, 8'h1B, 4'd8, 1'b0, 1'b1);
    run_op(8'h0D, 8'h0B, 8'h03, 4'd4, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule